// File: doc/BRIEF.md
# Host bus cycle follower

This block lets a fast internal core, clocked at about 100 MHz, take part in the bus cycles of a slower host whose phase-0 clock may be irregular or stretched. It does not generate the host timing. It oversamples the host phase-0 clock through a two-stage synchronizer and finds its falling edges. From that sampled clock it regenerates the two phase outputs. For each host cycle it drives one external access: address, R/W, write data and the opcode-fetch marker.

The internal core requests an access with `req_i` and holds the request fields until `done_o` pulses. Requests are launched at the next host cycle boundary. A read that ends while the host ready input is low is repeated in the following host cycle. When no request is pending, the block keeps the host bus alive by re-reading the last address. The fetch marker goes out in the same host cycle as the fetch address.

Top module: `hbf_follower`

## Requirements
- R1: While `rst_ni` is low: `addr_o` is 0, `rw_o` is 1 (read), `sync_o` is 0, `data_oe_o` is 0 and `done_o` is 0.
- R2: `phi2_o` equals `phi0_i` as sampled two internal clock edges earlier, and `phi1_o` is always its inverse.
- R3: `addr_o`, `rw_o` and `sync_o` change only on the internal clock edge one cycle after `phi2_o` falls. They are stable while `phi2_o` stays high.
- R4: A read request puts `req_addr_i` on `addr_o` with `rw_o` high for one host cycle. At the end of that cycle `rdata_o` holds the host data and `done_o` is high for exactly one internal clock, one clock after `phi2_o` goes low.
- R5: A write request drives `rw_o` low for one host cycle. `data_oe_o` is high only while `phi2_o` is high in that cycle, with `data_o` equal to `req_wdata_i`.
- R6: If `rdy_i` is low when a read cycle ends, the same read cycle repeats and `done_o` is withheld. The number of bus cycles carrying the address is one more than the number of low-ready cycle ends.
- R7: `rdy_i` has no effect on writes: a write always completes after one host cycle.
- R8: `sync_o` is high in exactly the host cycle that carries a fetch address (read with `req_fetch_i` high) and low in every other cycle. `sync_o` high implies `rw_o` high.
- R9: With no request pending, each host cycle is a read of the last address, with `sync_o` low and `data_oe_o` low.
- R10: Behaviour is correct for host periods that vary between cycles, including stretched cycles much longer than the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal fast clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| phi0_i | input | 1 | Host phase-0 clock (asynchronous) |
| rdy_i | input | 1 | Host ready, low stretches read cycles (asynchronous) |
| data_i | input | DW | Host data bus, read side (asynchronous) |
| phi1_o | output | 1 | Regenerated phase-1, inverse of sampled phase-0 |
| phi2_o | output | 1 | Regenerated phase-2, sampled phase-0 |
| addr_o | output | AW | Host address |
| rw_o | output | 1 | 1 = read, 0 = write |
| sync_o | output | 1 | Opcode-fetch marker |
| data_o | output | DW | Host data bus, write side |
| data_oe_o | output | 1 | Write data output enable |
| req_i | input | 1 | Core access request, held until done |
| req_we_i | input | 1 | Core request is a write |
| req_fetch_i | input | 1 | Core read is an opcode fetch |
| req_addr_i | input | AW | Core request address |
| req_wdata_i | input | DW | Core write data |
| rdata_o | output | DW | Read data returned to core |
| done_o | output | 1 | One-clock completion strobe |

## Verification
A wrong cycle state in this block shows up at the ports within one host cycle. The bus tuple can change while phase-2 is high. The completion strobe can come on a cycle whose address was stalled, or it can be missing or last two clocks. A read or a write can take the wrong number of host cycles under a low ready input. The fetch marker can land one cycle late, or stay on into an idle re-read. A faulty synchronizer or edge detector shows as regenerated phase edges that do not sit exactly two internal clocks behind the host clock. The bench watches for this on every internal clock under randomized and stretched host periods.

// File: rtl/hbf_pkg.sv
`timescale 1ns/1ps
package hbf_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_kind_e;
endpackage

// File: rtl/hbf_sync.sv
`timescale 1ns/1ps
module hbf_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[g] <= '0;
      else if (g == 0) stg_q[g] <= d_i;
      else stg_q[g] <= stg_q[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/hbf_edge.sv
`timescale 1ns/1ps
module hbf_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic fall_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  assign fall_o = lvl_q & ~lvl_i;
endmodule

// File: rtl/hbf_cycle.sv
`timescale 1ns/1ps
module hbf_cycle
  import hbf_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fall_i,
  input  logic          rdy_i,
  input  logic [DW-1:0] hdata_i,
  input  logic          req_i,
  input  logic          req_we_i,
  input  logic          req_fetch_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output cyc_kind_e     kind_o,
  output logic [AW-1:0] addr_o,
  output logic          sync_o,
  output logic [DW-1:0] wdata_o,
  output logic [DW-1:0] rdata_o,
  output logic          done_o
);
  cyc_kind_e     kind_q;
  logic [AW-1:0] addr_q;
  logic          sync_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          done_q;
  logic          rd_stall, rd_ok, wr_ok;

  assign rd_stall = (kind_q == CYC_READ) & ~rdy_i;
  assign rd_ok    = (kind_q == CYC_READ) &  rdy_i;
  assign wr_ok    = (kind_q == CYC_WRITE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q  <= CYC_IDLE;
      addr_q  <= '0;
      sync_q  <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (fall_i) begin
        if (rd_ok) rdata_q <= hdata_i;
        if (rd_ok || wr_ok) done_q <= 1'b1;
        if (rd_stall) begin
          // repeat the same read: hold tuple
        end else if (req_i && kind_q == CYC_IDLE) begin
          kind_q  <= req_we_i ? CYC_WRITE : CYC_READ;
          addr_q  <= req_addr_i;
          sync_q  <= req_fetch_i & ~req_we_i;
          wdata_q <= req_wdata_i;
        end else begin
          kind_q <= CYC_IDLE;
          sync_q <= 1'b0;
        end
      end
    end
  end

  assign kind_o  = kind_q;
  assign addr_o  = addr_q;
  assign sync_o  = sync_q;
  assign wdata_o = wdata_q;
  assign rdata_o = rdata_q;
  assign done_o  = done_q;
endmodule

// File: rtl/hbf_follower.sv
`timescale 1ns/1ps
module hbf_follower
  import hbf_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          phi0_i,
  input  logic          rdy_i,
  input  logic [DW-1:0] data_i,
  output logic          phi1_o,
  output logic          phi2_o,
  output logic [AW-1:0] addr_o,
  output logic          rw_o,
  output logic          sync_o,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  input  logic          req_i,
  input  logic          req_we_i,
  input  logic          req_fetch_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          done_o
);
  localparam int SW = DW + 2;

  logic [SW-1:0] raw_in, syn_in;
  logic          phi0_s, rdy_s, fall;
  logic [DW-1:0] data_s;
  cyc_kind_e     kind;

  assign raw_in = {phi0_i, rdy_i, data_i};

  hbf_sync #(.W(SW), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_in),
    .q_o   (syn_in)
  );

  assign {phi0_s, rdy_s, data_s} = syn_in;

  hbf_edge u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (phi0_s),
    .fall_o(fall)
  );

  hbf_cycle #(.AW(AW), .DW(DW)) u_cycle (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fall_i     (fall),
    .rdy_i      (rdy_s),
    .hdata_i    (data_s),
    .req_i      (req_i),
    .req_we_i   (req_we_i),
    .req_fetch_i(req_fetch_i),
    .req_addr_i (req_addr_i),
    .req_wdata_i(req_wdata_i),
    .kind_o     (kind),
    .addr_o     (addr_o),
    .sync_o     (sync_o),
    .wdata_o    (data_o),
    .rdata_o    (rdata_o),
    .done_o     (done_o)
  );

  assign phi2_o    = phi0_s;
  assign phi1_o    = ~phi0_s;
  assign rw_o      = (kind != CYC_WRITE);
  assign data_oe_o = (kind == CYC_WRITE) & phi0_s;
endmodule

// File: rtl/hbf_follower_chk.sv
`timescale 1ns/1ps
module hbf_follower_chk #(
  parameter int AW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          phi1_o,
  input logic          phi2_o,
  input logic [AW-1:0] addr_o,
  input logic          rw_o,
  input logic          sync_o,
  input logic          data_oe_o,
  input logic          done_o
);
  // R2
  phase_inv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phi1_o == !phi2_o);

  // R3
  tuple_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phi2_o && $past(phi2_o)) |-> ($stable(addr_o) && $stable(rw_o) && $stable(sync_o)));

  // R5
  oe_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(phi2_o) |-> !data_oe_o);

  // R5
  oe_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> !rw_o);

  // R8
  sync_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |-> rw_o);

  // R4
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R4
  done_place_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!phi2_o && $past(phi2_o, 2)));
endmodule

bind hbf_follower hbf_follower_chk #(.AW(AW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .phi1_o   (phi1_o),
  .phi2_o   (phi2_o),
  .addr_o   (addr_o),
  .rw_o     (rw_o),
  .sync_o   (sync_o),
  .data_oe_o(data_oe_o),
  .done_o   (done_o)
);

// File: tb/hbf_follower_test.sv
`timescale 1ns/1ps
module hbf_follower_test;
  localparam int AW = 16;
  localparam int DW = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n, phi0_i, rdy_i;
  logic [DW-1:0] data_i;
  logic          phi1_o, phi2_o, rw_o, sync_o, data_oe_o, done_o;
  logic [AW-1:0] addr_o;
  logic [DW-1:0] data_o, rdata_o;
  logic          req_i, req_we_i, req_fetch_i;
  logic [AW-1:0] req_addr_i;
  logic [DW-1:0] req_wdata_i;

  hbf_follower #(.AW(AW), .DW(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .phi0_i(phi0_i), .rdy_i(rdy_i), .data_i(data_i),
    .phi1_o(phi1_o), .phi2_o(phi2_o), .addr_o(addr_o), .rw_o(rw_o), .sync_o(sync_o),
    .data_o(data_o), .data_oe_o(data_oe_o), .req_i(req_i), .req_we_i(req_we_i),
    .req_fetch_i(req_fetch_i), .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .rdata_o(rdata_o), .done_o(done_o)
  );

  function automatic logic [DW-1:0] host_mem(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction
  assign data_i = host_mem(addr_o);

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // host clock and ready model
  int            stall_left = 0;
  logic [AW-1:0] stall_addr = '0;
  logic          stall_rw = 1'b1;
  int            stretch_cnt = 0;
  bit            host_run = 1'b0;

  initial begin
    phi0_i = 1'b0;
    rdy_i  = 1'b1;
    wait (host_run);
    forever begin
      int hi, lo;
      hi = (stretch_cnt > 0) ? 40 : int'($urandom_range(4, 10));
      if (stretch_cnt > 0) stretch_cnt--;
      lo = int'($urandom_range(4, 10));
      @(negedge clk);
      phi0_i = 1'b1;
      if (stall_left > 0 && addr_o == stall_addr && rw_o == stall_rw) begin
        rdy_i = 1'b0;
        stall_left--;
      end else rdy_i = 1'b1;
      repeat (hi - 1) @(negedge clk);
      @(negedge clk);
      phi0_i = 1'b0;
      repeat (lo - 1) @(negedge clk);
    end
  end

  // bus monitor
  logic [1:0]    h = '0;
  always @(posedge clk) h <= {h[0], phi0_i};

  bit            mon_en = 1'b0;
  logic          p1 = 1'b0, p2 = 1'b0;
  logic [AW+1:0] bus_prev = '0;
  int            phase_err = 0, ord_err = 0;
  logic [AW-1:0] log_addr = '0;
  logic          log_rw = 1'b1, log_sync = 1'b0;
  logic [AW-1:0] watch_addr = '0;
  logic          watch_rw = 1'b1;
  int            match_cnt = 0, cyc_cnt = 0, oe_cnt = 0, done_cnt = 0;
  logic [DW-1:0] last_wdata = '0;
  bit            idle_watch = 1'b0;
  logic [AW-1:0] idle_addr = '0;
  int            idle_bad = 0;

  always @(negedge clk) begin
    if (mon_en) begin
      if (phi2_o !== h[1] || phi1_o !== ~h[1]) phase_err++;
      if ({addr_o, rw_o, sync_o} !== bus_prev && !(phi2_o == 1'b0 && p1 == 1'b0 && p2 == 1'b1))
        ord_err++;
      if (phi2_o && !p1) begin
        log_addr = addr_o; log_rw = rw_o; log_sync = sync_o;
        cyc_cnt++;
        if (addr_o == watch_addr && rw_o == watch_rw) match_cnt++;
        if (idle_watch && !(addr_o == idle_addr && rw_o && !sync_o)) idle_bad++;
      end
      if (data_oe_o) begin oe_cnt++; last_wdata = data_o; end
      if (done_o) done_cnt++;
    end
    p2 = p1;
    p1 = phi2_o;
    bus_prev = {addr_o, rw_o, sync_o};
  end

  task automatic wait_done(output bit ok);
    int n = 0;
    @(negedge clk);
    while (!done_o && n < 4000) begin @(negedge clk); n++; end
    #1;
    ok = done_o;
  endtask

  task automatic core_read(input logic [AW-1:0] a, input logic fetch, input int stall, input string tag);
    bit ok;
    watch_addr = a; watch_rw = 1'b1; match_cnt = 0; oe_cnt = 0; done_cnt = 0;
    stall_addr = a; stall_rw = 1'b1; stall_left = stall;
    @(negedge clk);
    req_i = 1'b1; req_we_i = 1'b0; req_fetch_i = fetch; req_addr_i = a; req_wdata_i = '0;
    wait_done(ok);
    req_i = 1'b0;
    check(ok, tag, "read done seen", ok, 1);
    check(rdata_o == host_mem(a), "R4", "read data", rdata_o, host_mem(a));
    check(log_addr == a && log_rw, "R4", "address of completed cycle", log_addr, a);
    check(match_cnt == stall + 1, (stall > 0) ? "R6" : "R4", "cycles carrying address", match_cnt, stall + 1);
    check(log_sync == fetch, "R8", "fetch marker on cycle", log_sync, fetch);
    check(oe_cnt == 0, "R5", "no drive on read", oe_cnt, 0);
    repeat (3) @(negedge clk);
    #1;
    check(done_cnt == 1, "R4", "done pulse width", done_cnt, 1);
    stall_left = 0;
  endtask

  task automatic core_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input int stall);
    bit ok;
    watch_addr = a; watch_rw = 1'b0; match_cnt = 0; oe_cnt = 0; done_cnt = 0;
    stall_addr = a; stall_rw = 1'b0; stall_left = stall;
    @(negedge clk);
    req_i = 1'b1; req_we_i = 1'b1; req_fetch_i = 1'b1; req_addr_i = a; req_wdata_i = d;
    wait_done(ok);
    req_i = 1'b0;
    check(ok, "R5", "write done seen", ok, 1);
    check(log_addr == a && !log_rw, "R5", "write address", log_addr, a);
    check(!log_sync, "R8", "no marker on write", log_sync, 0);
    check(oe_cnt > 0 && last_wdata == d, "R5", "write data driven", last_wdata, d);
    check(match_cnt == 1, (stall > 0) ? "R7" : "R5", "write cycles", match_cnt, 1);
    repeat (3) @(negedge clk);
    #1;
    check(done_cnt == 1, "R4", "write done pulse", done_cnt, 1);
    stall_left = 0;
  endtask

  task automatic idle_check(input logic [AW-1:0] last_a);
    int c0, oe0, n;
    c0 = cyc_cnt; oe0 = oe_cnt; n = 0;
    idle_addr = last_a; idle_bad = 0; idle_watch = 1'b1;
    while (cyc_cnt < c0 + 3 && n < 4000) begin @(negedge clk); n++; end
    #1;
    idle_watch = 1'b0;
    check(cyc_cnt >= c0 + 3, "R9", "idle cycles keep running", cyc_cnt - c0, 3);
    check(idle_bad == 0, "R9", "idle cycles re-read last address", idle_bad, 0);
    check(oe_cnt == oe0, "R9", "no drive when idle", oe_cnt - oe0, 0);
  endtask

  initial begin
    #(150000 * 8);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    req_i = 1'b0; req_we_i = 1'b0; req_fetch_i = 1'b0; req_addr_i = '0; req_wdata_i = '0;
    repeat (5) @(negedge clk);
    // R1
    check(addr_o == '0, "R1", "reset addr", addr_o, 0);
    check(rw_o == 1'b1 && sync_o == 1'b0, "R1", "reset rw/sync", {rw_o, sync_o}, 2'b10);
    check(!data_oe_o && !done_o, "R1", "reset oe/done", {data_oe_o, done_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_en = 1'b1;
    host_run = 1'b1;

    core_read(16'h1234, 1'b1, 0, "R4");
    core_read(16'h2001, 1'b0, 0, "R4");
    idle_check(16'h2001);
    core_write(16'h3456, 8'h9C, 0);
    core_read(16'h40F0, 1'b1, 2, "R6");
    core_write(16'h5511, 8'h3E, 3);
    core_read(16'h6066, 1'b0, 1, "R6");
    stretch_cnt = 3;
    core_read(16'h7777, 1'b1, 0, "R10");
    core_read(16'h8A0B, 1'b0, 0, "R10");
    idle_check(16'h8A0B);

    check(phase_err == 0, "R2", "phase outputs vs sampled host clock", phase_err, 0);
    check(ord_err == 0, "R3", "bus tuple change placement", ord_err, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule